// File: doc/BRIEF.md
# Timeslot Strobe and Gated Bit Clock Generator

This block marks chosen byte slots of a 12-slot time-division backplane frame for devices that have no frame timing of their own. It runs on the backplane data clock, which in double-clock mode is twice the bit rate. A rising edge on the frame sync input starts each frame. From the data clock it counts data-clock phases, bits and slots, and it drives two strobe outputs plus one gated bit clock. The gated clock carries bit-clock pulses only while a strobe window that is routed to it is open. It is held at 0 everywhere else.

Each strobe channel has an 8-bit setting: a base slot, three enables that open the window in the base slot, in the slot after it and in the slot three after it, and a flag that routes the window to the gated clock. Offsets that run past the last slot wrap back to slot 0. A host writes the settings at any time. A new setting is held in a pending copy and only comes into use when the next frame begins, so a window is never cut short or stretched part-way through a frame.

The frame timer is a three-state machine. ST_HUNT is the state after reset, before any frame sync has been seen. ST_RUN counts a frame. ST_HOLD is entered when a full frame has been counted and no new sync has arrived. The transitions are: ST_HUNT to ST_RUN on a sync edge; ST_RUN to ST_RUN (restart at slot 0) on a sync edge; ST_RUN to ST_HOLD after the last phase of the last slot with no sync edge; ST_HOLD to ST_RUN on a sync edge. All outputs are 0 outside ST_RUN.

Top module: `sds_strobe_gen`

## Requirements
- R1: After reset both channel settings are 0x00. Both strobes and the gated clock stay 0 until the first rising edge of `fsync_i`.
- R2: A frame starts at the clock edge where `fsync_i` is first sampled high after being low. The outputs for frame cycle 0 appear just after that edge. Slot s covers frame cycles 16*s to 16*s+15 (8 bits of 2 data-clock cycles each).
- R3: A write with `cfg_we_i` high stores `cfg_data_i` as the pending setting of channel `cfg_ch_i`. The fields are: bits [3:0] base slot, bit 4 enable for base+0, bit 5 enable for base+1, bit 6 enable for base+3, bit 7 route the window to the gated clock.
- R4: A strobe is 1 throughout every slot in its window and 0 in all other slots. The window is the base slot, base+1 and base+3 (each modulo 12), each present when its enable is set, in any combination.
- R5: A base slot value of 12 to 15 opens no window for that channel, whatever its enables are.
- R6: `gclk_o` is 1 on the odd frame cycles (the second data-clock cycle of each bit) inside the window of at least one channel whose route bit is set. It is 0 in every other cycle.
- R7: A pending setting comes into use at the next frame start. A write in the middle of a frame has no effect on the rest of that frame.
- R8: If 192 frame cycles pass with no new sync edge, all outputs go to 0 and stay 0 until the next rising edge of `fsync_i`.
- R9: A sync edge that arrives before a frame is complete restarts counting at slot 0 of a new frame.
- R10: The two channels are independent. The windows of both channels may overlap or differ, and each strobe follows only its own setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane data clock (two cycles per bit) |
| rst_n | input | 1 | Active-low reset |
| fsync_i | input | 1 | Frame sync; its rising edge starts a frame |
| cfg_we_i | input | 1 | Setting write enable |
| cfg_ch_i | input | 1 | Channel selected by the write |
| cfg_data_i | input | 8 | Setting value written |
| strb_o | output | 2 | Strobe output of each channel |
| gclk_o | output | 1 | Gated bit clock |

## Verification
If the slot counter is wrong, every window shows it within one frame: a strobe that is one slot early or late is visible at the first slot boundary after the frame start. A wrong phase counter shows up on the gated clock in the first open window, as pulses on even cycles or pulses of double width. If the state machine sticks in ST_RUN, the outputs do not fall to 0 during a frame that has no sync edge. If a pending setting is applied too early, a strobe changes within the same frame as the write, and the check picks this up in the cycles right after the write.

// File: rtl/sds_pkg.sv
package sds_pkg;

    // Width of the base slot field; also the width of slot indices.
    localparam int SEL_W = 4;

    // One channel setting, 8 bits.
    typedef struct packed {
        logic             clk_route;
        logic             en_p3;
        logic             en_p1;
        logic             en_p0;
        logic [SEL_W-1:0] base;
    } sds_cfg_t;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } sds_state_t;

endpackage

// File: rtl/sds_frame_timer.sv
module sds_frame_timer
    import sds_pkg::*;
#(
    parameter int SLOTS       = 12,
    parameter int SLOT_BITS   = 8,
    parameter int DCL_PER_BIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync_i,
    output logic             frame_start_o,
    output sds_state_t       state_o,
    output logic             slot_start_o,
    output logic             nxt_run_o,
    output logic [SEL_W-1:0] nxt_slot_o,
    output logic             nxt_bit_hi_o
);

    localparam int PH_W = (DCL_PER_BIT > 1) ? $clog2(DCL_PER_BIT) : 1;
    localparam int BT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(DCL_PER_BIT - 1);
    localparam logic [PH_W-1:0]  PH_HALF = PH_W'(DCL_PER_BIT / 2);
    localparam logic [BT_W-1:0]  BT_LAST = BT_W'(SLOT_BITS - 1);
    localparam logic [SEL_W-1:0] SL_LAST = SEL_W'(SLOTS - 1);

    sds_state_t       st_q, st_n;
    logic             fs_q;
    logic [PH_W-1:0]  ph_q, ph_n;
    logic [BT_W-1:0]  bt_q, bt_n;
    logic [SEL_W-1:0] sl_q, sl_n;
    logic             fs_edge;
    logic             at_end;

    assign fs_edge = fsync_i & ~fs_q;
    assign at_end  = (ph_q == PH_LAST) && (bt_q == BT_LAST) && (sl_q == SL_LAST);

    // Next-state and counter logic
    always_comb begin
        st_n = st_q;
        ph_n = ph_q;
        bt_n = bt_q;
        sl_n = sl_q;
        unique case (st_q)
            ST_HUNT: begin
                if (fs_edge) begin
                    st_n = ST_RUN;
                    ph_n = '0;
                    bt_n = '0;
                    sl_n = '0;
                end
            end
            ST_RUN: begin
                if (fs_edge) begin
                    ph_n = '0;
                    bt_n = '0;
                    sl_n = '0;
                end else if (at_end) begin
                    st_n = ST_HOLD;
                    ph_n = '0;
                    bt_n = '0;
                    sl_n = '0;
                end else if (ph_q == PH_LAST) begin
                    ph_n = '0;
                    if (bt_q == BT_LAST) begin
                        bt_n = '0;
                        sl_n = sl_q + 1'b1;
                    end else begin
                        bt_n = bt_q + 1'b1;
                    end
                end else begin
                    ph_n = ph_q + 1'b1;
                end
            end
            ST_HOLD: begin
                if (fs_edge) begin
                    st_n = ST_RUN;
                    ph_n = '0;
                    bt_n = '0;
                    sl_n = '0;
                end
            end
            default: begin
                st_n = ST_HUNT;
                ph_n = '0;
                bt_n = '0;
                sl_n = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_HUNT;
            fs_q <= 1'b0;
            ph_q <= '0;
            bt_q <= '0;
            sl_q <= '0;
        end else begin
            st_q <= st_n;
            fs_q <= fsync_i;
            ph_q <= ph_n;
            bt_q <= bt_n;
            sl_q <= sl_n;
        end
    end

    assign frame_start_o = fs_edge;
    assign state_o       = st_q;
    assign slot_start_o  = (ph_q == '0) && (bt_q == '0);
    assign nxt_run_o     = (st_n == ST_RUN);
    assign nxt_slot_o    = sl_n;
    assign nxt_bit_hi_o  = (ph_n >= PH_HALF);

endmodule

// File: rtl/sds_cfg_bank.sv
module sds_cfg_bank
    import sds_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [CH_W-1:0]       ch_i,
    input  logic [7:0]            data_i,
    input  logic                  frame_start_i,
    output sds_cfg_t [NUM_CH-1:0] active_o,
    output sds_cfg_t [NUM_CH-1:0] nxt_active_o
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        sds_cfg_t pend_q;
        sds_cfg_t act_q;
        logic     sel_me;

        assign sel_me          = we_i && (ch_i == CH_W'(i));
        assign nxt_active_o[i] = frame_start_i ? pend_q : act_q;
        assign active_o[i]     = act_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q <= '0;
                act_q  <= '0;
            end else begin
                if (sel_me) begin
                    pend_q <= sds_cfg_t'(data_i);
                end
                act_q <= nxt_active_o[i];
            end
        end
    end

endmodule

// File: rtl/sds_slot_decode.sv
module sds_slot_decode
    import sds_pkg::*;
#(
    parameter int SLOTS = 12
) (
    input  sds_cfg_t         cfg_i,
    input  logic [SEL_W-1:0] slot_i,
    output logic             hit_o
);

    localparam int N_OFF = 3;
    localparam int OFFS [N_OFF] = '{0, 1, 3};

    logic             base_ok;
    logic [N_OFF-1:0] en_vec;
    logic [N_OFF-1:0] match;

    assign base_ok = ({1'b0, cfg_i.base} < (SEL_W+1)'(SLOTS));
    assign en_vec  = {cfg_i.en_p3, cfg_i.en_p1, cfg_i.en_p0};

    for (genvar j = 0; j < N_OFF; j++) begin : g_off
        logic [SEL_W:0]   sum;
        logic [SEL_W-1:0] tgt;
        always_comb begin
            sum = {1'b0, cfg_i.base} + (SEL_W+1)'(OFFS[j]);
            if (sum >= (SEL_W+1)'(SLOTS)) begin
                sum = sum - (SEL_W+1)'(SLOTS);
            end
            tgt = sum[SEL_W-1:0];
        end
        assign match[j] = en_vec[j] && (slot_i == tgt);
    end

    assign hit_o = base_ok && (|match);

endmodule

// File: rtl/sds_strobe_gen.sv
module sds_strobe_gen
    import sds_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int SLOTS       = 12,
    parameter int SLOT_BITS   = 8,
    parameter int DCL_PER_BIT = 2,
    parameter int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync_i,
    input  logic              cfg_we_i,
    input  logic [CH_W-1:0]   cfg_ch_i,
    input  logic [7:0]        cfg_data_i,
    output logic [NUM_CH-1:0] strb_o,
    output logic              gclk_o
);

    sds_state_t            tmr_state;
    logic                  frame_start;
    logic                  slot_start;
    logic                  nxt_run;
    logic [SEL_W-1:0]      nxt_slot;
    logic                  nxt_bit_hi;
    sds_cfg_t [NUM_CH-1:0] cfg_active;
    sds_cfg_t [NUM_CH-1:0] cfg_next;
    logic [NUM_CH-1:0]     hit_n;
    logic [NUM_CH-1:0]     route_n;
    logic [NUM_CH-1:0]     strb_q;
    logic                  gclk_q;

    sds_frame_timer #(
        .SLOTS      (SLOTS),
        .SLOT_BITS  (SLOT_BITS),
        .DCL_PER_BIT(DCL_PER_BIT)
    ) timer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fsync_i      (fsync_i),
        .frame_start_o(frame_start),
        .state_o      (tmr_state),
        .slot_start_o (slot_start),
        .nxt_run_o    (nxt_run),
        .nxt_slot_o   (nxt_slot),
        .nxt_bit_hi_o (nxt_bit_hi)
    );

    sds_cfg_bank #(
        .NUM_CH(NUM_CH),
        .CH_W  (CH_W)
    ) bank_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_i         (cfg_we_i),
        .ch_i         (cfg_ch_i),
        .data_i       (cfg_data_i),
        .frame_start_i(frame_start),
        .active_o     (cfg_active),
        .nxt_active_o (cfg_next)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        sds_slot_decode #(
            .SLOTS(SLOTS)
        ) dec_i (
            .cfg_i (cfg_next[i]),
            .slot_i(nxt_slot),
            .hit_o (hit_n[i])
        );
        assign route_n[i] = cfg_next[i].clk_route;
    end

    // Output registers: loaded with the value for the coming cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_q <= '0;
            gclk_q <= 1'b0;
        end else begin
            strb_q <= nxt_run ? hit_n : '0;
            gclk_q <= nxt_run && nxt_bit_hi && (|(hit_n & route_n));
        end
    end

    assign strb_o = strb_q;
    assign gclk_o = gclk_q;

endmodule

// File: rtl/sds_strobe_chk.sv
module sds_strobe_chk
    import sds_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int SLOTS  = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  sds_state_t            state_i,
    input  logic                  frame_start_i,
    input  logic                  slot_start_i,
    input  sds_cfg_t [NUM_CH-1:0] active_i,
    input  logic [NUM_CH-1:0]     strb_i,
    input  logic                  gclk_i
);

    logic [NUM_CH-1:0] route_vec;
    for (genvar i = 0; i < NUM_CH; i++) begin : g_rt
        assign route_vec[i] = active_i[i].clk_route;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != ST_RUN) |-> (strb_i == '0 && !gclk_i)); // R1

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_HOLD) |-> !gclk_i); // R8

    AST_STROBE_SLOT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(strb_i) |-> slot_start_i); // R4

    AST_CFG_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_i |=> $stable(active_i)); // R7

    AST_GCLK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        gclk_i |-> (|(strb_i & route_vec))); // R6

    for (genvar i = 0; i < NUM_CH; i++) begin : g_bad
        AST_BAD_BASE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            ({1'b0, active_i[i].base} >= (SEL_W+1)'(SLOTS)) |-> !strb_i[i]); // R5
    end

endmodule

bind sds_strobe_gen sds_strobe_chk #(
    .NUM_CH(NUM_CH),
    .SLOTS (SLOTS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_i      (tmr_state),
    .frame_start_i(frame_start),
    .slot_start_i (slot_start),
    .active_i     (cfg_active),
    .strb_i       (strb_q),
    .gclk_i       (gclk_q)
);

// File: tb/sds_strobe_gen_tb_top.sv
module sds_strobe_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       cfg_we = 1'b0;
    logic [0:0] cfg_ch = 1'b0;
    logic [7:0] cfg_data = 8'h00;
    logic [1:0] strb;
    logic       gclk;

    int total = 0;
    int bad = 0;
    int frame_no = 0;
    bit done = 1'b0;

    logic [7:0] sh0 = 8'h00, sh1 = 8'h00;   // expected pending settings
    logic [7:0] act0 = 8'h00, act1 = 8'h00; // expected settings in use

    always #10 clk = ~clk; // 50 MHz

    sds_strobe_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync_i   (fsync),
        .cfg_we_i  (cfg_we),
        .cfg_ch_i  (cfg_ch),
        .cfg_data_i(cfg_data),
        .strb_o    (strb),
        .gclk_o    (gclk)
    );

    // Window membership worked out from the field layout of R3/R4/R5
    function automatic bit in_win(logic [7:0] c, int slot);
        int b = int'(c[3:0]);
        if (b > 11) return 1'b0;
        return (c[4] && slot == b) ||
               (c[5] && slot == (b + 1) % 12) ||
               (c[6] && slot == (b + 3) % 12);
    endfunction

    task automatic chk(input string tag, input logic got, input logic exp, input int k);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b (frame %0d cycle %0d)",
                     tag, got, exp, frame_no, k);
        end
    endtask

    task automatic run_frame(input int len, input bit sync, input bit wr,
                             input logic [7:0] w0, input logic [7:0] w1,
                             input string ctx);
        bit run = sync;
        if (sync) begin
            act0 = sh0;
            act1 = sh1;
            fsync = 1'b1;
        end
        for (int k = 0; k < len; k++) begin
            int slot;
            bit hi, e0, e1, eg;
            string t0, t1, tg;
            @(negedge clk);
            slot = k / 16;
            hi   = (k % 2) == 1;
            e0   = run && in_win(act0, slot);
            e1   = run && in_win(act1, slot);
            eg   = run && hi && ((e0 && act0[7]) || (e1 && act1[7]));
            if (ctx != "") begin
                t0 = ctx; t1 = ctx; tg = ctx;
            end else if (k == 0) begin
                t0 = "R2"; t1 = "R2"; tg = "R2";
            end else if (wr && k > 102) begin
                t0 = "R7"; t1 = "R7"; tg = "R7";
            end else begin
                t0 = (act0[3:0] > 4'd11) ? "R5" : "R4";
                t1 = (act1[3:0] > 4'd11) ? "R5" : "R10";
                tg = "R6";
            end
            chk(t0, strb[0], e0, k);
            chk(t1, strb[1], e1, k);
            chk(tg, gclk, eg, k);
            if (k == 3) fsync = 1'b0;
            // R3: write path, one channel per cycle
            if (wr && k == 100) begin
                cfg_we = 1'b1; cfg_ch = 1'b0; cfg_data = w0; sh0 = w0;
            end
            if (wr && k == 101) begin
                cfg_ch = 1'b1; cfg_data = w1; sh1 = w1;
            end
            if (wr && k == 102) cfg_we = 1'b0;
        end
        frame_no++;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog: got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet before any frame sync
        run_frame(30, 1'b0, 1'b0, 8'h00, 8'h00, "R1");
        // R1: settings are zero after reset, so first frame is quiet
        run_frame(192, 1'b1, 1'b0, 8'h00, 8'h00, "R1");
        // Sweep every base value and every enable combination (R4, R5, R6, R10)
        for (int b = 0; b < 16; b++) begin
            for (int e = 0; e < 8; e++) begin
                logic [7:0] w0, w1;
                w0 = {1'b1, 3'(e), 4'(b)};
                w1 = {1'(b % 2), ~3'(e), 4'((b + 5) % 16)};
                run_frame(192, 1'b1, 1'b1, w0, w1, "");
            end
        end
        run_frame(192, 1'b1, 1'b1, 8'hF9, 8'h7A, "");
        run_frame(192, 1'b1, 1'b0, 8'h00, 8'h00, "");
        // R8: no sync after a full frame
        run_frame(192, 1'b0, 1'b0, 8'h00, 8'h00, "R8");
        run_frame(192, 1'b1, 1'b1, 8'hFA, 8'hF0, "");
        // R9: early sync restarts the frame
        run_frame(50, 1'b1, 1'b0, 8'h00, 8'h00, "R9");
        run_frame(192, 1'b1, 1'b0, 8'h00, 8'h00, "R9");
        run_frame(40, 1'b1, 1'b0, 8'h00, 8'h00, "R9");
        run_frame(192, 1'b1, 1'b0, 8'h00, 8'h00, "R9");
        done = 1'b1;
        summary();
        $finish;
    end

endmodule